// File: doc/BRIEF.md
# Byte-wide Memory Chip-Enable Decoder

This block sits between a processor core and a non-multiplexed byte-wide memory bus. Every cycle it takes one access request (a 16-bit address, whether the access is a program fetch or a data access, and whether it is a write) and turns it into active-low chip enables for up to four memory parts, active-low enables for four memory-mapped peripherals, and an active-low write enable. All of these outputs are registered, so the enables change only on clock edges.

Program space and data space are placed in one 17-bit linear space: program space is the lower 64 KB and data space the upper 64 KB. A size-select input picks between four 32 KB parts, each with its own chip enable, and one 128 KB part. In 128 KB mode the second and third enable pins carry linear address bits 16 and 15, and the fourth pin is held high. A peripheral-map input sends data accesses to four 16 KB peripheral windows instead of memory. A program-limit input bounds the program fetches that the byte-wide bus serves. Fetches above the limit raise a not-mapped flag for a fallback bus and drive no enable. Writes aimed at program space are refused. A core reset flag forces every enable and the write enable inactive.

Top module: `bwbus_decoder`

## Requirements
- R1: While `rst` or `core_rst` is high at a clock edge, the outputs after that edge are: every `mem_ce_n` bit 1, every `periph_en_n` bit 1, `mem_we_n` 1 and `not_mapped` 0.
- R2: With `big_part`=0, a memory access uses bank index {space, addr[15]}, where space is 0 for program and 1 for data. Bank 0 drives `mem_ce_n[0]` low, bank 1 `mem_ce_n[1]`, bank 2 `mem_ce_n[2]` and bank 3 `mem_ce_n[3]`. All other bits stay high.
- R3: With `big_part`=1, a memory access drives `mem_ce_n[0]` low, `mem_ce_n[1]` = linear bit 16 (1 for data space) and `mem_ce_n[2]` = addr[15].
- R4: With `periph_map`=1, a data access drives `periph_en_n[addr[15:14]]` low and leaves every `mem_ce_n` bit high.
- R5: A program fetch whose address is not below `prog_limit` (a 17-bit bound: fetch is mapped when {0,addr} < prog_limit) drives no enable and sets `not_mapped` to 1.
- R6: A write with `acc_prog`=1 drives no enable, keeps `mem_we_n` at 1 and leaves `not_mapped` at 0.
- R7: A mapped data write drives `mem_we_n` low in the same cycle as its enable. A read keeps `mem_we_n` high.
- R8: Every output takes the value decoded from the inputs sampled at the previous rising edge. An input change between edges does not reach the outputs.
- R9: With `big_part`=0, at most one `mem_ce_n` bit is low. A memory enable and a peripheral enable are never low together. A program fetch never drives a peripheral enable.
- R10: When `acc_valid` is 0, the next outputs are all enables high, `mem_we_n` 1 and `not_mapped` 0.
- R11: With `big_part`=1, `mem_ce_n[3]` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| core_rst | input | 1 | Core reset state flag; forces outputs inactive |
| acc_valid | input | 1 | An access is requested this cycle |
| acc_prog | input | 1 | 1 = program space, 0 = data space |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 16 | Access address |
| big_part | input | 1 | 1 = single 128 KB part, 0 = four 32 KB parts |
| periph_map | input | 1 | 1 = data space goes to peripheral windows |
| prog_limit | input | 17 | Program fetches below this bound are mapped |
| mem_ce_n | output | 4 | Memory chip enables (pins 1 and 2 carry address in 128 KB mode) |
| periph_en_n | output | 4 | Peripheral enables, one per 16 KB data window |
| mem_we_n | output | 1 | Active-low write enable |
| not_mapped | output | 1 | Program fetch outside the mapped range |

## Verification
The bench goes after the program-limit boundary, comparing a fetch at limit minus one with one at the limit, and after the limit values 0 and 10000h. A design with an off-by-one compare would serve or drop the wrong byte. It checks writes aimed at program space, where a faulty decoder would pull the write enable low and corrupt code. It also checks that the peripheral map removes every memory enable, where a design that also fired a chip enable would give two drivers on the data bus. In 128 KB mode it checks that pins 1 and 2 follow address bits 16 and 15, not a one-hot pattern, and that the fourth pin stays high. Mid-cycle input changes check that no output moves before the clock edge.

// File: rtl/bwd_pkg.sv
package bwd_pkg;
  typedef enum logic [1:0] {
    TGT_NONE     = 2'd0,
    TGT_MEM      = 2'd1,
    TGT_PERIPH   = 2'd2,
    TGT_UNMAPPED = 2'd3
  } target_e;
endpackage

// File: rtl/bwd_classify.sv
module bwd_classify
  import bwd_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              hold_off,
  input  logic              acc_valid,
  input  logic              acc_prog,
  input  logic              acc_write,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              periph_map,
  input  logic [ADDR_W:0]   prog_limit,
  output target_e           tgt,
  output logic              wr_ok
);
  logic below_limit;

  assign below_limit = {1'b0, acc_addr} < prog_limit;

  always_comb begin
    tgt   = TGT_NONE;
    wr_ok = 1'b0;
    if (!hold_off && acc_valid) begin
      if (acc_prog) begin
        if (acc_write)        tgt = TGT_NONE;
        else if (below_limit) tgt = TGT_MEM;
        else                  tgt = TGT_UNMAPPED;
      end else begin
        tgt   = periph_map ? TGT_PERIPH : TGT_MEM;
        wr_ok = acc_write;
      end
    end
  end
endmodule

// File: rtl/bwd_bank_decode.sv
module bwd_bank_decode #(
  parameter int NUM_CE = 4,
  localparam int SEL_W = $clog2(NUM_CE)
) (
  input  logic             active,
  input  logic             big_part,
  input  logic [SEL_W-1:0] bank,
  output logic [NUM_CE-1:0] ce_n
);
  for (genvar g = 0; g < NUM_CE; g++) begin : g_pin
    logic small_sel;
    logic big_val;
    assign small_sel = active && (bank == SEL_W'(g));
    if (g == 0) begin : g_main
      assign big_val = !active;
    end else if (g == 1) begin : g_hi_bit
      assign big_val = active ? bank[SEL_W-1] : 1'b1;
    end else if (g == 2) begin : g_lo_bit
      assign big_val = active ? bank[SEL_W-2] : 1'b1;
    end else begin : g_spare
      assign big_val = 1'b1;
    end
    assign ce_n[g] = big_part ? big_val : !small_sel;
  end
endmodule

// File: rtl/bwd_periph_decode.sv
module bwd_periph_decode #(
  parameter int NUM_PE = 4,
  localparam int PSEL_W = $clog2(NUM_PE)
) (
  input  logic              active,
  input  logic [PSEL_W-1:0] window,
  output logic [NUM_PE-1:0] pe_n
);
  for (genvar g = 0; g < NUM_PE; g++) begin : g_win
    assign pe_n[g] = !(active && (window == PSEL_W'(g)));
  end
endmodule

// File: rtl/bwbus_decoder.sv
module bwbus_decoder
  import bwd_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int NUM_CE = 4,
  parameter int NUM_PE = 4,
  localparam int SEL_W  = $clog2(NUM_CE),
  localparam int PSEL_W = $clog2(NUM_PE)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              core_rst,
  input  logic              acc_valid,
  input  logic              acc_prog,
  input  logic              acc_write,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              big_part,
  input  logic              periph_map,
  input  logic [ADDR_W:0]   prog_limit,
  output logic [NUM_CE-1:0] mem_ce_n,
  output logic [NUM_PE-1:0] periph_en_n,
  output logic              mem_we_n,
  output logic              not_mapped
);
  target_e          tgt;
  logic             wr_ok;
  logic [ADDR_W:0]  lin_addr;
  logic [NUM_CE-1:0] ce_n_d;
  logic [NUM_PE-1:0] pe_n_d;

  // program space low half, data space high half of a linear space
  assign lin_addr = {!acc_prog, acc_addr};

  bwd_classify #(.ADDR_W(ADDR_W)) cls_i (
    .hold_off  (core_rst),
    .acc_valid (acc_valid),
    .acc_prog  (acc_prog),
    .acc_write (acc_write),
    .acc_addr  (acc_addr),
    .periph_map(periph_map),
    .prog_limit(prog_limit),
    .tgt       (tgt),
    .wr_ok     (wr_ok)
  );

  bwd_bank_decode #(.NUM_CE(NUM_CE)) bank_i (
    .active  (tgt == TGT_MEM),
    .big_part(big_part),
    .bank    (lin_addr[ADDR_W -: SEL_W]),
    .ce_n    (ce_n_d)
  );

  bwd_periph_decode #(.NUM_PE(NUM_PE)) per_i (
    .active(tgt == TGT_PERIPH),
    .window(acc_addr[ADDR_W-1 -: PSEL_W]),
    .pe_n  (pe_n_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_ce_n    <= '1;
      periph_en_n <= '1;
      mem_we_n    <= 1'b1;
      not_mapped  <= 1'b0;
    end else begin
      mem_ce_n    <= ce_n_d;
      periph_en_n <= pe_n_d;
      mem_we_n    <= !wr_ok;
      not_mapped  <= (tgt == TGT_UNMAPPED);
    end
  end
endmodule

// File: rtl/bwd_checker.sv
module bwd_checker #(
  parameter int NUM_CE = 4,
  parameter int NUM_PE = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              core_rst,
  input logic              acc_valid,
  input logic              acc_prog,
  input logic              acc_write,
  input logic              big_part,
  input logic [NUM_CE-1:0] mem_ce_n,
  input logic [NUM_PE-1:0] periph_en_n,
  input logic              mem_we_n,
  input logic              not_mapped
);
  p_reset_idle_r1: assert property (@(posedge clk) disable iff (rst)
    core_rst |=> (mem_ce_n == '1 && periph_en_n == '1 && mem_we_n && !not_mapped));

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    !acc_valid |=> (mem_ce_n == '1 && periph_en_n == '1 && mem_we_n && !not_mapped));

  p_single_ce_r9: assert property (@(posedge clk) disable iff (rst)
    !big_part |=> ($countones(~mem_ce_n) <= 1));

  p_no_overlap_r9: assert property (@(posedge clk) disable iff (rst)
    !big_part |=> !((mem_ce_n != '1) && (periph_en_n != '1)));

  p_fetch_no_pe_r9: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_prog) |=> (periph_en_n == '1));

  p_ce4_high_r11: assert property (@(posedge clk) disable iff (rst)
    big_part |=> mem_ce_n[NUM_CE-1]);

  p_unmapped_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    not_mapped |-> (periph_en_n == '1 && mem_we_n));

  p_prog_write_blocked_r6: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_prog && acc_write) |=> (mem_we_n && !not_mapped && periph_en_n == '1));

  p_we_needs_enable_r7: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> ((mem_ce_n != '1) || (periph_en_n != '1)));
endmodule

bind bwbus_decoder bwd_checker #(.NUM_CE(NUM_CE), .NUM_PE(NUM_PE)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .core_rst   (core_rst),
  .acc_valid  (acc_valid),
  .acc_prog   (acc_prog),
  .acc_write  (acc_write),
  .big_part   (big_part),
  .mem_ce_n   (mem_ce_n),
  .periph_en_n(periph_en_n),
  .mem_we_n   (mem_we_n),
  .not_mapped (not_mapped)
);

// File: tb/bwbus_decoder_tb_top.sv
`timescale 1ns/1ps
module bwbus_decoder_tb_top;
  logic        clk = 1'b0;
  logic        rst, core_rst, acc_valid, acc_prog, acc_write, big_part, periph_map;
  logic [15:0] acc_addr;
  logic [16:0] prog_limit;
  logic [3:0]  mem_ce_n, periph_en_n;
  logic        mem_we_n, not_mapped;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done   = 0;

  logic [9:0] exp_q;
  string      tag_q;
  bit         exp_valid = 0;
  bit         big_q = 0;

  always #5 clk = ~clk;

  bwbus_decoder dut_i (
    .clk(clk), .rst(rst), .core_rst(core_rst), .acc_valid(acc_valid),
    .acc_prog(acc_prog), .acc_write(acc_write), .acc_addr(acc_addr),
    .big_part(big_part), .periph_map(periph_map), .prog_limit(prog_limit),
    .mem_ce_n(mem_ce_n), .periph_en_n(periph_en_n), .mem_we_n(mem_we_n),
    .not_mapped(not_mapped)
  );

  function automatic logic [9:0] outs();
    return {not_mapped, mem_we_n, periph_en_n, mem_ce_n};
  endfunction

  // Behavioural reference: {not_mapped, we_n, pe_n[3:0], ce_n[3:0]}
  function automatic logic [9:0] model(bit r, bit cr, bit v, bit p, bit w,
                                       int a, bit big, bit per, int lim, output string tag);
    logic [3:0] ce = 4'hF, pe = 4'hF;
    bit we = 1, nm = 0, mem = 0;
    int lin;
    if (r || cr) begin tag = "R1"; return 10'b01_1111_1111; end
    if (!v) begin tag = "R10"; return 10'b01_1111_1111; end
    if (p) begin
      if (w) begin tag = "R6"; return 10'b01_1111_1111; end
      if (a >= lim) begin tag = "R5"; return 10'b11_1111_1111; end
      lin = a; mem = 1;
    end else if (per) begin
      pe[a / 16384] = 1'b0; we = !w;
      tag = w ? "R4 R7" : "R4";
      return {nm, we, pe, ce};
    end else begin
      lin = 65536 + a; mem = 1; we = !w;
    end
    if (mem) begin
      if (big) begin
        ce[0] = 1'b0; ce[1] = (lin / 65536) % 2 == 1; ce[2] = (lin / 32768) % 2 == 1; ce[3] = 1'b1;
        tag = "R3 R11";
      end else begin
        ce[lin / 32768] = 1'b0;
        tag = "R2";
      end
      if (!p && w) tag = {tag, " R7"};
    end
    return {nm, we, pe, ce};
  endfunction

  task automatic check(string tag, logic [9:0] act, logic [9:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic step(bit r, bit cr, bit v, bit p, bit w, int a, bit big, bit per, int lim);
    logic [9:0] held;
    int zeros;
    @(negedge clk);
    if (exp_valid) begin
      check(tag_q, outs(), exp_q);
      if (!big_q) begin
        zeros = 0;
        for (int i = 0; i < 4; i++) if (!mem_ce_n[i]) zeros++;
        check("R9 single ce", {9'd0, zeros > 1}, 10'd0);
        check("R9 ce/pe overlap", {9'd0, (mem_ce_n != 4'hF) && (periph_en_n != 4'hF)}, 10'd0);
      end
    end
    held = outs();
    rst = r; core_rst = cr; acc_valid = v; acc_prog = p; acc_write = w;
    acc_addr = a[15:0]; big_part = big; periph_map = per; prog_limit = lim[16:0];
    #1;
    check("R8 no change before edge", outs(), held);
    exp_q = model(r, cr, v, p, w, a, big, per, lim, tag_q);
    big_q = big;
    exp_valid = 1;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      errors++; checks++;
      $display("FAIL watchdog: got %0d cycles expected under 20000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst = 1; core_rst = 0; acc_valid = 0; acc_prog = 0; acc_write = 0;
    acc_addr = 0; big_part = 0; periph_map = 0; prog_limit = 0;
    // R1 reset state, with a request pending
    step(1, 0, 1, 0, 1, 16'h1234, 0, 0, 17'h10000);
    step(1, 0, 1, 1, 0, 16'h0000, 1, 0, 17'h10000);
    // R2 four 32 KB banks
    step(0, 0, 1, 1, 0, 16'h0100, 0, 0, 17'h10000);
    step(0, 0, 1, 1, 0, 16'h9000, 0, 0, 17'h10000);
    step(0, 0, 1, 0, 0, 16'h1234, 0, 0, 17'h10000);
    step(0, 0, 1, 0, 1, 16'hF000, 0, 0, 17'h10000); // R7 write
    // R3 R11 single 128 KB part
    step(0, 0, 1, 1, 0, 16'h8000, 1, 0, 17'h10000);
    step(0, 0, 1, 1, 0, 16'h7FFF, 1, 0, 17'h10000);
    step(0, 0, 1, 0, 1, 16'hC001, 1, 0, 17'h10000);
    step(0, 0, 1, 0, 0, 16'h0003, 1, 0, 17'h10000);
    // R4 peripheral windows, each quadrant edge
    step(0, 0, 1, 0, 0, 16'h0000, 0, 1, 17'h10000);
    step(0, 0, 1, 0, 1, 16'h7FFF, 0, 1, 17'h10000);
    step(0, 0, 1, 0, 0, 16'h8000, 1, 1, 17'h10000);
    step(0, 0, 1, 0, 1, 16'hFFFF, 0, 1, 17'h10000);
    step(0, 0, 1, 1, 0, 16'h4000, 0, 1, 17'h10000); // R9 fetch ignores periph_map
    // R5 limit boundary
    step(0, 0, 1, 1, 0, 16'h2FFF, 0, 0, 17'h03000);
    step(0, 0, 1, 1, 0, 16'h3000, 0, 0, 17'h03000);
    step(0, 0, 1, 1, 0, 16'h0000, 0, 0, 17'h00000);
    step(0, 0, 1, 1, 0, 16'hFFFF, 1, 0, 17'h10000);
    step(0, 0, 1, 1, 0, 16'hFFFF, 1, 0, 17'h0FFFF);
    // R6 program writes blocked
    step(0, 0, 1, 1, 1, 16'h0010, 0, 0, 17'h10000);
    step(0, 0, 1, 1, 1, 16'hA000, 1, 1, 17'h00000);
    // R10 idle, R1 core reset mid-stream
    step(0, 0, 0, 0, 1, 16'h1000, 0, 0, 17'h10000);
    step(0, 1, 1, 0, 1, 16'h1000, 0, 1, 17'h10000);
    step(0, 1, 1, 1, 0, 16'h1000, 1, 0, 17'h10000);
    step(0, 0, 1, 0, 0, 16'h1000, 0, 0, 17'h10000);
    // Mixed random traffic
    for (int i = 0; i < 1500; i++) begin
      int lim;
      case ($urandom % 4)
        0: lim = 0;
        1: lim = 17'h10000;
        default: lim = $urandom % 17'h10001;
      endcase
      step(($urandom % 50) == 0, ($urandom % 20) == 0, ($urandom % 8) != 0,
           $urandom % 2, $urandom % 2, $urandom % 65536, $urandom % 2, $urandom % 2, lim);
    end
    step(0, 0, 0, 0, 0, 0, 0, 0, 0);
    @(negedge clk);
    check(tag_q, outs(), exp_q);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule